// File: doc/BRIEF.md
# Direct-Mapped Write-Back Line Cache

This block is a direct-mapped data cache between a CPU port that issues single 32-bit word reads and writes, and a memory port that transfers whole 128-bit lines of four words. Stores that hit are kept in the cache only, and the line is marked modified. A modified line goes out to memory only when a miss needs its slot. A store that misses first brings the line in, and then merges the store word into it.

The CPU raises `cpu_req` for one cycle while `cpu_stall` is low. On a hit, `cpu_done` pulses in the next cycle and, for a read, carries the word on `cpu_rdata`. On a miss, `cpu_stall` rises in the next cycle. The controller then writes back the victim, if it is valid and modified, and refills the line. It replays the access against the new line and drops `cpu_stall` in the same cycle that `cpu_done` pulses. `cpu_req` is not sampled while `cpu_stall` is high. The memory side holds each request until a one-cycle `mem_ack`, which also carries the refill data.

Top module: `wb_line_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_stall`, `cpu_done` and `mem_req` are low, and the first access to any address misses.
- R2: The address is split as follows: the tag is bits 31 down to 4+INDEX_W, the line index is bits 4+INDEX_W-1 down to 4, the word-in-line offset is bits 3..2, and bits 1..0 are ignored.
- R3: A read hit raises `cpu_done` with the addressed word on `cpu_rdata` in the cycle after the request, with `cpu_stall` low and no memory request.
- R4: A write hit changes only the addressed word of the line, issues no memory request and marks the line modified.
- R5: On a miss, `cpu_stall` is high from the cycle after the request until the replayed access completes, and it falls in the same cycle that `cpu_done` pulses.
- R6: A miss whose victim is invalid or unmodified issues exactly one memory read (`mem_we`=0) at the line-aligned miss address, and no write.
- R7: A miss whose victim is valid and modified first writes the victim's 128-bit line to the address built from {victim tag, index, 4'b0000}, and then reads the new line.
- R8: A write miss refills the line, then merges the store word into it and marks the line modified, so a later eviction writes back the merged data.
- R9: Word w of a line occupies bits 32w+31..32w of `mem_rdata` and `mem_wdata`.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we` and `mem_addr` stay stable. Each `mem_ack` completes one line transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, sampled while not stalled |
| cpu_we | input | 1 | 1 = word write, 0 = word read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Store word |
| cpu_rdata | output | 32 | Load result, valid with cpu_done on reads |
| cpu_done | output | 1 | One-cycle pulse when an access completes |
| cpu_stall | output | 1 | High while a miss is being serviced |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = line write-back, 0 = line refill |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Victim line for write-back |
| mem_ack | input | 1 | One-cycle transfer completion |
| mem_rdata | input | 128 | Refill line, valid with mem_ack |

## Verification
The bench builds the cache with INDEX_W=4, which gives 16 lines and a 24-bit tag. Addresses 256 bytes apart then fall on the same line, so conflict evictions of both clean and modified victims come within a few accesses. The memory model answers after two cycles, which makes the request-hold window of R10 observable. A long pseudo-random run over three tags and four lines mixes read and write hits, write misses and dirty evictions back to back.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int AW    = 32;
  localparam int WW    = 32;
  localparam int WPL   = 4;
  localparam int LW    = WW * WPL;
  localparam int SEL_W = $clog2(WPL);
  localparam int LOW_W = SEL_W + 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_DONE  = 2'd3
  } ctl_state_e;

  // word position inside a line
  function automatic logic [SEL_W-1:0] word_sel(input logic [AW-1:0] a);
    return a[LOW_W-1:2];
  endfunction

  // address with the in-line offset cleared
  function automatic logic [AW-1:0] line_base(input logic [AW-1:0] a);
    return {a[AW-1:LOW_W], {LOW_W{1'b0}}};
  endfunction
endpackage

// File: rtl/wbc_store.sv
module wbc_store
  import wbc_pkg::*;
#(
  parameter int INDEX_W = 12,
  parameter int TAG_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic               rd_valid,
  output logic               rd_dirty,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [LW-1:0]      rd_line,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [LW-1:0]      wr_line,
  input  logic               wr_dirty
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [LW-1:0]    data_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_line;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = data_q[rd_idx];

  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dirty |-> rd_valid); // R4
endmodule

// File: rtl/wbc_lane.sv
module wbc_lane
  import wbc_pkg::*;
(
  input  logic [LW-1:0]    line_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [WW-1:0]    wdata_i,
  output logic [WW-1:0]    word_o,
  output logic [LW-1:0]    merged_o
);
  logic [WW-1:0] words [WPL];

  for (genvar w = 0; w < WPL; w++) begin : g_word
    assign words[w] = line_i[w*WW +: WW];
    assign merged_o[w*WW +: WW] = (sel_i == SEL_W'(w)) ? wdata_i : line_i[w*WW +: WW];
  end

  assign word_o = words[sel_i];
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [WW-1:0]   cpu_wdata,
  input  logic            hit,
  input  logic            victim_dirty,
  input  logic            mem_ack,
  output ctl_state_e      state_o,
  output logic            lat_we,
  output logic [AW-1:0]   lat_addr,
  output logic [WW-1:0]   lat_wdata
);
  ctl_state_e state_q, state_d;
  logic       take_miss;

  assign take_miss = (state_q == ST_IDLE) && cpu_req && !hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (take_miss) state_d = victim_dirty ? ST_WBACK : ST_FILL;
      ST_WBACK: if (mem_ack) state_d = ST_FILL;
      ST_FILL:  if (mem_ack) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      lat_we    <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else begin
      state_q <= state_d;
      if (take_miss) begin
        lat_we    <= cpu_we;
        lat_addr  <= cpu_addr;
        lat_wdata <= cpu_wdata;
      end
    end
  end

  assign state_o = state_q;

  AST_REPLAY_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |-> ($past(state_q) == ST_FILL)); // R5
  AST_WBACK_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    take_miss && !victim_dirty |=> (state_q == ST_FILL)); // R6
endmodule

// File: rtl/wb_line_cache.sv
module wb_line_cache
  import wbc_pkg::*;
#(
  parameter int INDEX_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [31:0]   cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  output logic          cpu_done,
  output logic          cpu_stall,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [127:0]  mem_wdata,
  input  logic          mem_ack,
  input  logic [127:0]  mem_rdata
);
  localparam int TAG_W = AW - INDEX_W - LOW_W;

  ctl_state_e         state;
  logic               lat_we;
  logic [AW-1:0]      lat_addr;
  logic [WW-1:0]      lat_wdata;

  logic               in_idle;
  logic [AW-1:0]      look_addr;
  logic [WW-1:0]      look_wdata;
  logic [INDEX_W-1:0] look_idx;
  logic [TAG_W-1:0]   look_tag;

  logic               rd_valid, rd_dirty;
  logic [TAG_W-1:0]   rd_tag;
  logic [LW-1:0]      rd_line;
  logic [WW-1:0]      rd_word;
  logic [LW-1:0]      merged;

  logic               hit, victim_dirty;
  logic               acc_go, hit_evt, miss_evt, wb_evt, fill_evt, replay_evt;

  logic               wr_en, wr_dirty;
  logic [TAG_W-1:0]   wr_tag;
  logic [LW-1:0]      wr_line;

  logic [AW-1:0]      wb_addr, fill_addr;
  logic               done_q;
  logic [WW-1:0]      rdata_q;

  // the lookup follows the CPU address when idle, the held miss otherwise
  assign in_idle    = (state == ST_IDLE);
  assign look_addr  = in_idle ? cpu_addr  : lat_addr;
  assign look_wdata = in_idle ? cpu_wdata : lat_wdata;
  assign look_idx   = look_addr[LOW_W +: INDEX_W];
  assign look_tag   = look_addr[AW-1 -: TAG_W];

  wbc_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (look_idx),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .rd_tag   (rd_tag),
    .rd_line  (rd_line),
    .wr_en    (wr_en),
    .wr_idx   (look_idx),
    .wr_tag   (wr_tag),
    .wr_line  (wr_line),
    .wr_dirty (wr_dirty)
  );

  wbc_lane u_lane (
    .line_i   (rd_line),
    .sel_i    (word_sel(look_addr)),
    .wdata_i  (look_wdata),
    .word_o   (rd_word),
    .merged_o (merged)
  );

  assign hit          = rd_valid && (rd_tag == look_tag);
  assign victim_dirty = rd_valid && rd_dirty;

  // named events
  assign acc_go     = in_idle && cpu_req;
  assign hit_evt    = acc_go && hit;
  assign miss_evt   = acc_go && !hit;
  assign wb_evt     = (state == ST_WBACK) && mem_ack;
  assign fill_evt   = (state == ST_FILL) && mem_ack;
  assign replay_evt = (state == ST_DONE);

  wbc_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .hit          (hit),
    .victim_dirty (victim_dirty),
    .mem_ack      (mem_ack),
    .state_o      (state),
    .lat_we       (lat_we),
    .lat_addr     (lat_addr),
    .lat_wdata    (lat_wdata)
  );

  // one store write port: write hit, refill, or replayed store
  always_comb begin
    wr_en    = 1'b0;
    wr_dirty = 1'b0;
    wr_tag   = look_tag;
    wr_line  = merged;
    if (hit_evt && cpu_we) begin
      wr_en    = 1'b1;
      wr_dirty = 1'b1;
    end else if (fill_evt) begin
      wr_en    = 1'b1;
      wr_line  = mem_rdata;
    end else if (replay_evt && lat_we) begin
      wr_en    = 1'b1;
      wr_dirty = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= hit_evt || replay_evt;
      if (hit_evt || replay_evt) rdata_q <= rd_word;
    end
  end

  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
  assign cpu_stall = !in_idle;

  assign wb_addr   = {rd_tag, lat_addr[LOW_W +: INDEX_W], {LOW_W{1'b0}}};
  assign fill_addr = line_base(lat_addr);

  assign mem_req   = (state == ST_WBACK) || (state == ST_FILL);
  assign mem_we    = (state == ST_WBACK);
  assign mem_addr  = (state == ST_WBACK) ? wb_addr : fill_addr;
  assign mem_wdata = rd_line;

  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> cpu_done && !cpu_stall && !mem_req); // R3
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> cpu_stall && !cpu_done); // R5
  AST_CLEAN_SKIPS_WB: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt && !victim_dirty |=> mem_req && !mem_we); // R6
  AST_DIRTY_WB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt && victim_dirty |=> mem_req && mem_we); // R7
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    wb_evt |=> mem_req && !mem_we && (mem_addr == $past(fill_addr))); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr)); // R10
  AST_FILL_REPLAYS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> cpu_stall && !mem_req); // R5
endmodule

// File: tb/sim_wb_line_cache.sv
module sim_wb_line_cache;
  localparam int IW  = 4;
  localparam int NL  = 1 << IW;
  localparam int TW  = 32 - IW - 4;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_done, cpu_stall;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;

  wb_line_cache #(.INDEX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit idle_phase = 1'b0;

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [127:0] mem_img [int unsigned];

  function automatic logic [127:0] seed_line(input int unsigned la);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[32*w +: 32] = (la * 32'd7) ^ (32'hC0DE_0000 + 32'(w));
    return l;
  endfunction

  function automatic logic [127:0] mem_get(input int unsigned la);
    if (mem_img.exists(la)) return mem_img[la];
    return seed_line(la);
  endfunction

  typedef struct packed { logic we; logic [31:0] addr; logic [127:0] data; } xact_t;
  xact_t got_q[$];
  int wait_cnt = 0;
  logic [31:0] held_addr = '0;
  logic        held_we = 1'b0;

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wait_cnt = 0;
    end else if (rst_n && mem_req) begin
      wait_cnt++;
      if (wait_cnt == 1) begin
        held_addr = mem_addr;
        held_we = mem_we;
      end else begin
        chk(mem_addr == held_addr && mem_we == held_we, "R10 request held stable",
            {mem_we, mem_addr}, {held_we, held_addr});
      end
      if (wait_cnt >= LAT) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem_img[mem_addr] = mem_wdata;
          got_q.push_back('{1'b1, mem_addr, mem_wdata});
        end else begin
          mem_rdata = mem_get(mem_addr);
          got_q.push_back('{1'b0, mem_addr, mem_rdata});
        end
      end
    end
  end

  // quiet memory port whenever no miss is in flight
  always @(negedge clk) begin
    if (rst_n && idle_phase) chk(!mem_req && !cpu_stall, "R3 idle/hit memory port quiet",
                                 {mem_req, cpu_stall}, 0);
  end

  // ---------------- reference cache ----------------
  bit           rv [NL];
  bit           rdty [NL];
  logic [TW-1:0] rtag [NL];
  logic [127:0] rdat [NL];

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd, input string lbl);
    int idx;
    int w;
    int cyc;
    logic [TW-1:0] t;
    logic [TW-1:0] vt;
    logic [127:0] line;
    logic [127:0] old;
    bit hit;
    bit wb;
    logic [31:0] base;
    int nexp;
    idx  = int'(a[4 +: IW]);
    w    = int'(a[3:2]);
    t    = a[31 -: TW];
    hit  = rv[idx] && rtag[idx] == t;
    wb   = !hit && rv[idx] && rdty[idx];
    vt   = rtag[idx];
    old  = rdat[idx];
    base = {a[31:4], 4'b0000};
    got_q.delete();
    idle_phase = hit;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    if (hit) begin
      chk(cpu_done && !cpu_stall, {lbl, " R3 hit completes next cycle"}, {cpu_done, cpu_stall}, 2'b10);
      line = rdat[idx];
    end else begin
      chk(cpu_stall && !cpu_done, {lbl, " R5 miss stalls"}, {cpu_stall, cpu_done}, 2'b10);
      cyc = 0;
      while (!cpu_done && cyc < 50) begin
        @(negedge clk);
        cyc++;
        if (!cpu_done) chk(cpu_stall, {lbl, " R5 stall held"}, cpu_stall, 1);
      end
      chk(cpu_done && !cpu_stall, {lbl, " R5 stall drops with done"}, {cpu_done, cpu_stall}, 2'b10);
      line = mem_get(base);
      nexp = wb ? 2 : 1;
      chk(got_q.size() == nexp, {lbl, wb ? " R7 transfer count" : " R6 transfer count"}, got_q.size(), nexp);
      if (got_q.size() == nexp) begin
        if (wb) begin
          chk(got_q[0].we && got_q[0].addr == {vt, a[4 +: IW], 4'b0000} && got_q[0].data == old,
              {lbl, " R7 victim written back"}, got_q[0].data, old);
          chk(!got_q[1].we && got_q[1].addr == base, {lbl, " R7 refill after write-back"},
              {got_q[1].we, got_q[1].addr}, {1'b0, base});
        end else begin
          chk(!got_q[0].we && got_q[0].addr == base, {lbl, " R6 clean refill only"},
              {got_q[0].we, got_q[0].addr}, {1'b0, base});
        end
      end
    end
    if (hit) chk(got_q.size() == 0, {lbl, we ? " R4 write hit no memory" : " R3 read hit no memory"}, got_q.size(), 0);
    if (!we) chk(cpu_rdata == line[32*w +: 32], {lbl, " R9 read word"}, cpu_rdata, line[32*w +: 32]);
    if (we) line[32*w +: 32] = wd;
    rv[idx]   = 1'b1;
    rtag[idx] = t;
    rdat[idx] = line;
    rdty[idx] = hit ? (rdty[idx] | we) : we;
    idle_phase = 1'b1;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] x;
    for (int i = 0; i < NL; i++) begin rv[i] = 0; rdty[i] = 0; rtag[i] = '0; rdat[i] = '0; end
    repeat (3) @(negedge clk);
    chk(!cpu_stall && !cpu_done && !mem_req, "R1 outputs quiet in reset", {cpu_stall, cpu_done, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_stall && !cpu_done && !mem_req, "R1 outputs quiet after reset", {cpu_stall, cpu_done, mem_req}, 0);
    idle_phase = 1'b1;

    access(0, 32'h0000_0104, '0, "R1 first read misses");
    access(0, 32'h0000_0107, '0, "R2 byte bits ignored");
    access(1, 32'h0000_010A, 32'hAAAA_5555, "R4 write hit");
    access(0, 32'h0000_0108, '0, "R4 written word");
    access(0, 32'h0000_010C, '0, "R4 neighbour word unchanged");
    access(0, 32'h0000_0100, '0, "R4 word0 unchanged");
    access(0, 32'h0000_0204, '0, "R7 dirty conflict");
    access(0, 32'h0000_0108, '0, "R7 written data from memory");
    access(1, 32'h0000_0318, 32'h1234_5678, "R8 write miss");
    access(0, 32'h0000_0318, '0, "R8 merged word");
    access(0, 32'h0000_031C, '0, "R8 refilled neighbour");
    access(0, 32'h0000_0414, '0, "R8 evict merged line");
    access(0, 32'h0000_0318, '0, "R8 merged word survives");
    access(0, 32'h0001_0020, '0, "R2 high tag bit");
    access(0, 32'h0000_0020, '0, "R2 tag differs only high");

    x = 32'h1357_9BDF;
    for (int k = 0; k < 200; k++) begin
      logic [31:0] a;
      x = x * 32'd1103515245 + 32'd12345;
      a = {20'h0, 4'(1 + (x[27:26] % 3)), 2'b00, x[21:20], x[19:18], x[17:16]};
      access(x[24], a, x ^ 32'h5A5A_A5A5, "R9 mixed stream");
    end
    finish_run();
  end
endmodule